// File: doc/BRIEF.md
# NAND Single-Bit ECC Checker and Corrector

This block takes the 24-bit check code that was stored in the spare area of a NAND page and the 24-bit code freshly computed over the same 512-byte block. It XORs the two codes to form a syndrome and sorts the outcome into one of four cases:

- no error;
- a single flipped data bit, reported with its byte index and bit mask;
- a single flipped bit inside the stored code itself, where the data is left untouched;
- an error it cannot fix.

The result appears one clock after a valid strobe, together with a one-cycle done pulse. An optional fix mode applies the reported bit flip to a byte presented on a data port, so that a caller can stream the faulty byte through the block.

The block size is a parameter. When a syndrome decodes to a byte index at or beyond the block size, the result is reported as uncorrectable.

Top module: `nand_ecc_fix`

## Requirements
- R1: When the stored and calculated codes are equal, the result has status 2'b00, byte index 0 and bit mask 0.
- R2: When the syndrome (calculated XOR stored) has its upper 12 bits equal to the bitwise complement of its lower 12 bits, and the byte index is inside the block, the result is as follows. Status is 2'b01. Byte index is syndrome bits 23:15. Bit mask is 1 shifted left by syndrome bits 14:12.
- R3: A syndrome that passes the complement test but whose byte index is not below BLOCK_BYTES gives status 2'b11, byte index 0 and mask 0.
- R4: A syndrome with exactly one bit set gives status 2'b10 (error in the stored code only), byte index 0 and mask 0.
- R5: Any other nonzero syndrome gives status 2'b11, byte index 0 and mask 0.
- R6: done is high for exactly the one cycle after a cycle with in_valid high. All result outputs change only in that cycle and hold otherwise.
- R7: In the result cycle, data_out equals data_in XOR bit mask when fix_en was high with the strobe and the status is 2'b01. Otherwise it equals data_in as sampled with the strobe.
- R8: After reset, done, status, byte index, bit mask and data_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: codes and data are sampled |
| code_stored | input | 24 | Code read back from the spare area |
| code_calc | input | 24 | Code computed over the data block |
| fix_en | input | 1 | Apply the bit flip to data_in |
| data_in | input | 8 | Byte to pass through or repair |
| done | output | 1 | Result valid, one-cycle pulse |
| status | output | 2 | 00 none, 01 data corrected, 10 code-only error, 11 uncorrectable |
| byte_idx | output | 9 | Byte in the block holding the bad bit |
| bit_mask | output | 8 | One-hot mask of the bad bit |
| data_out | output | 8 | Passed-through or repaired byte |

## Verification
The case that is hardest to reach is an out-of-range byte index. It needs a syndrome whose halves are exact complements and whose upper bits point past the block end. With the default size of 512, every 9-bit index is inside the block, so the case cannot occur at all. The bench therefore runs a second instance with a 300-byte block and builds complement syndromes arithmetically for indices on both sides of 300. It also sweeps all 4096 byte and bit positions, all 24 one-hot syndromes and all two-bit syndromes through the default instance.

// File: rtl/nand_ecc_fix.sv
module nand_ecc_fix #(
  parameter int CODE_W      = 24,
  parameter int BLOCK_BYTES = 512
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [CODE_W-1:0]                    code_stored,
  input  logic [CODE_W-1:0]                    code_calc,
  input  logic                                 fix_en,
  input  logic [7:0]                           data_in,
  output logic                                 done,
  output logic [1:0]                           status,
  output logic [CODE_W-CODE_W/2-4:0]           byte_idx,
  output logic [7:0]                           bit_mask,
  output logic [7:0]                           data_out
);
  localparam int HALF_W = CODE_W / 2;
  localparam int BIT_W  = 3;
  localparam int IDX_W  = CODE_W - HALF_W - BIT_W;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(BLOCK_BYTES);

  localparam logic [1:0] ST_NONE = 2'b00;
  localparam logic [1:0] ST_DATA = 2'b01;
  localparam logic [1:0] ST_CODE = 2'b10;
  localparam logic [1:0] ST_BAD  = 2'b11;

  logic [CODE_W-1:0] syn;
  logic [HALF_W-1:0] syn_hi, syn_lo;
  logic [IDX_W-1:0]  loc_byte;
  logic [BIT_W-1:0]  loc_bit;
  logic              is_zero, is_cmp, is_pow2, in_range;

  assign syn      = code_calc ^ code_stored;
  assign syn_hi   = syn[CODE_W-1:HALF_W];
  assign syn_lo   = syn[HALF_W-1:0];
  assign loc_byte = syn[CODE_W-1:HALF_W+BIT_W];
  assign loc_bit  = syn[HALF_W+BIT_W-1:HALF_W];
  assign is_zero  = (syn == '0);
  assign is_cmp   = ((syn_hi ^ syn_lo) == '1);
  assign is_pow2  = !is_zero && ((syn & (syn - 1'b1)) == '0);
  assign in_range = ({1'b0, loc_byte} < LIMIT);

  logic [1:0]       st_n;
  logic [IDX_W-1:0] idx_n;
  logic [7:0]       mask_n;

  always_comb begin
    st_n   = ST_BAD;
    idx_n  = '0;
    mask_n = '0;
    if (is_zero) begin
      st_n = ST_NONE;
    end else if (is_cmp) begin
      if (in_range) begin
        st_n   = ST_DATA;
        idx_n  = loc_byte;
        mask_n = 8'b1 << loc_bit;
      end
    end else if (is_pow2) begin
      st_n = ST_CODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= ST_NONE;
      byte_idx <= '0;
      bit_mask <= '0;
      data_out <= '0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        status   <= st_n;
        byte_idx <= idx_n;
        bit_mask <= mask_n;
        data_out <= fix_en ? (data_in ^ mask_n) : data_in;
      end
    end
  end

  p_equal_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && code_stored == code_calc) |=> (status == ST_NONE && bit_mask == 8'h00));

  p_mask_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_DATA) |-> ($countones(bit_mask) == 1 && {1'b0, byte_idx} < LIMIT));

  p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_DATA) |-> (bit_mask == 8'h00 && byte_idx == '0));

  p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && $stable(status) && $stable(data_out)));

  p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fix_en) |=> (data_out == $past(data_in)));
endmodule

// File: tb/test_nand_ecc_fix.sv
module test_nand_ecc_fix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] code_stored = '0, code_calc = '0;
  logic        fix_en = 1'b0;
  logic [7:0]  data_in = '0;
  logic        done, s_done;
  logic [1:0]  status, s_status;
  logic [8:0]  byte_idx, s_byte_idx;
  logic [7:0]  bit_mask, s_bit_mask, data_out, s_data_out;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  nand_ecc_fix i_nand_ecc_fix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code_stored(code_stored),
    .code_calc(code_calc), .fix_en(fix_en), .data_in(data_in), .done(done),
    .status(status), .byte_idx(byte_idx), .bit_mask(bit_mask), .data_out(data_out));

  nand_ecc_fix #(.CODE_W(24), .BLOCK_BYTES(300)) i_small (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code_stored(code_stored),
    .code_calc(code_calc), .fix_en(fix_en), .data_in(data_in), .done(s_done),
    .status(s_status), .byte_idx(s_byte_idx), .bit_mask(s_bit_mask), .data_out(s_data_out));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic apply(logic [23:0] st, logic [23:0] syn, logic fx, logic [7:0] d);
    @(negedge clk);
    code_stored = st; code_calc = st ^ syn; fix_en = fx; data_in = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_main(string req, int st, int idx, int msk, int dout);
    chk("R6", "done", int'(done), 1);
    chk(req, "status", int'(status), st);
    chk(req, "byte_idx", int'(byte_idx), idx);
    chk(req, "bit_mask", int'(bit_mask), msk);
    chk("R7", "data_out", int'(data_out), dout);
  endtask

  initial begin
    logic [23:0] base;
    #1;
    chk("R8", "done", int'(done), 0);
    chk("R8", "status", int'(status), 0);
    chk("R8", "byte_idx", int'(byte_idx), 0);
    chk("R8", "bit_mask", int'(bit_mask), 0);
    chk("R8", "data_out", int'(data_out), 0);
    #22 rst_n = 1'b1;

    // R1: equal codes, several stored values
    for (int k = 0; k < 8; k++) begin
      base = 24'h5A3C0F * (k + 1);
      apply(base, 24'h0, k[0], 8'(k * 37));
      expect_main("R1", 0, 0, 0, (k * 37) & 8'hFF);
    end

    // R2 / R7: every byte and bit position
    for (int b = 0; b < 512; b++) begin
      for (int t = 0; t < 8; t++) begin
        logic [11:0] up;
        logic [7:0]  d, m;
        up   = 12'((b << 3) | t);
        base = 24'((b * 7919 + t * 131) & 24'hFFFFFF);
        d    = 8'(b ^ (t * 29));
        m    = 8'(1 << t);
        apply(base, {up, ~up}, t[0], d);
        expect_main("R2", 1, b, m, t[0] ? int'(d ^ m) : int'(d));
      end
    end

    // R4: one-hot syndromes, error in stored code
    for (int i = 0; i < 24; i++) begin
      apply(24'hC0FFEE, 24'(1 << i), 1'b1, 8'hA5);
      expect_main("R4", 2, 0, 0, 8'hA5);
    end

    // R5: all two-bit syndromes
    for (int i = 0; i < 24; i++) begin
      for (int j = i + 1; j < 24; j++) begin
        apply(24'h123456, 24'((1 << i) | (1 << j)), 1'b1, 8'h3C);
        expect_main("R5", 3, 0, 0, 8'h3C);
      end
    end
    // R5: complement test almost met (one bit short)
    apply(24'h0, 24'hABC543 ^ 24'h000001, 1'b0, 8'h11);
    expect_main("R5", 3, 0, 0, 8'h11);

    // R3: boundary on the 300-byte instance
    for (int b = 290; b < 312; b++) begin
      logic [11:0] up;
      up = 12'((b << 3) | 5);
      apply(24'h0F0F0F, {up, ~up}, 1'b1, 8'h00);
      if (b < 300) begin
        chk("R3", "small status", int'(s_status), 1);
        chk("R3", "small idx", int'(s_byte_idx), b);
        chk("R3", "small data_out", int'(s_data_out), 8'h20);
      end else begin
        chk("R3", "small status", int'(s_status), 3);
        chk("R3", "small idx", int'(s_byte_idx), 0);
        chk("R3", "small mask", int'(s_bit_mask), 0);
        chk("R3", "small data_out", int'(s_data_out), 8'h00);
      end
      chk("R3", "main status", int'(status), 1);
    end

    // R6: outputs hold and done drops when idle
    apply(24'h0, 24'h000FFF ^ 24'h000000, 1'b1, 8'hF0);
    @(negedge clk);
    chk("R6", "done idle", int'(done), 0);
    chk("R6", "status hold", int'(status), 1);
    chk("R6", "idx hold", int'(byte_idx), 0);
    chk("R6", "mask hold", int'(bit_mask), 1);
    chk("R6", "data hold", int'(data_out), 8'hF1);
    code_calc = 24'hFFFFFF; data_in = 8'h00;
    @(negedge clk);
    chk("R6", "status ignore", int'(status), 1);
    chk("R6", "data ignore", int'(data_out), 8'hF1);
    chk("R6", "done ignore", int'(done), 0);

    finish_run();
  end
endmodule